// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block holds the four resource-manager registers of a serial-bus node: the bus manager identity, the remaining isochronous bandwidth, and the two 32-bit halves of the channel allocation bitmap. Remote nodes claim and release these resources only through compare-and-swap lock requests. The block answers each request with the value that tells the requester whether its claim succeeded. Quadlet reads return the current contents. Plain writes are refused.

Requests arrive one per cycle on a flat request port. Each request carries a kind (read, write or lock), a byte offset, an extended lock code, a data word and an argument word. Every request gets exactly one response on the next cycle, so each read-modify-write is atomic with respect to all other requests. A bus-reset input puts all four registers back to their power-up contents. The request presented in that cycle is dropped.

The bandwidth register does not use plain compare-swap. The difference between argument and data is taken from the pool or returned to it, within its limits. The channel registers toggle only the bits in which argument and data differ, and only when the register agrees with the argument on those bits. Channel 31 is held permanently allocated in the high word, bit 0.

Top module: `iso_resmgr_regs`

## Requirements
- R1: After rst_n low or a bus_reset cycle, the registers hold these values: manager ID at offset 0x0 = 0x3F, bandwidth at offset 0x4 = 4915 (0x1333), channel high word at offset 0x8 = 0xFFFFFFFE, channel low word at offset 0xC = 0xFFFFFFFF.
- R2: A request with req_valid high gives rsp_valid high on the following cycle, and never at any other time. A read (req_kind 0) of an aligned offset in the group returns the register with rsp_code 0 (complete).
- R3: A lock (req_kind 2, req_ext 2) on the manager ID returns the old value. The register takes req_data only if the old value equals req_arg.
- R4: For a bandwidth lock with req_arg above 0x1FFF, the register is unchanged and its old value is returned. req_data is reduced to its low 13 bits before use.
- R5: For a bandwidth lock with arg >= data, amount = arg - data. If the register holds at least that amount, it drops by the amount and arg is returned. Otherwise the register is unchanged and its value is returned.
- R6: For a bandwidth lock with arg < data, amount = data - arg. If register + amount < 0x2000, the register rises by the amount and arg is returned. Otherwise the register is unchanged and its value is returned.
- R7: For a channel-word lock, mask = arg XOR data. If the register equals arg on every mask bit, the register is XORed with the mask and arg is returned. Otherwise the current register value is returned and nothing changes.
- R8: Before a lock on the channel high word, bit 0 of data is forced to 0, so channel 31 (high word bit 0) always reads 0 (allocated).
- R9: A write (req_kind 1) to any register of the group answers rsp_code 1 (type error) with rsp_value 0, and changes no register.
- R10: A request whose offset has bits [1:0] nonzero answers rsp_code 1. An aligned offset of 0x10 or above answers rsp_code 2 (address error). A lock with req_ext other than 2, or req_kind 3, answers rsp_code 1. None of these change a register.
- R11: A request presented in a cycle where bus_reset is high gets no response and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Reload reset values; drops the request of the same cycle |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 lock, 3 invalid |
| req_addr | input | ADDR_W | Byte offset within the register group |
| req_ext | input | EXT_W | Extended lock code; 2 = compare-swap |
| req_data | input | 32 | Lock data (new value) |
| req_arg | input | 32 | Lock argument (expected value) |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_value | output | 32 | Read data or lock old value; 0 on error |

## Verification
A wrong register value cannot be seen directly, because the registers are visible only through responses. The stimulus therefore chains locks so that each response depends on the state left by earlier requests. A corrupted bandwidth or channel word shows up in the rsp_value of the next lock or read on that offset, one cycle after it is issued. Refused requests are followed by reads of the same register, so that a forbidden update shows at the ports. The channel 31 guard and the bus-reset reload are each confirmed by a read in the cycle right after the event.

// File: rtl/iso_resmgr_regs.sv
module iso_resmgr_regs #(
  parameter int          ADDR_W   = 6,
  parameter int          EXT_W    = 4,
  parameter int          CAS_CODE = 2,
  parameter int          BW_W     = 13,
  parameter int          BW_INIT  = 4915,
  parameter logic [31:0] MGR_INIT = 32'h0000_003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [EXT_W-1:0]  req_ext,
  input  logic [31:0]       req_data,
  input  logic [31:0]       req_arg,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [31:0]       rsp_value
);
  localparam logic [1:0] K_READ = 2'd0, K_WRITE = 2'd1, K_LOCK = 2'd2;
  localparam logic [1:0] C_OK = 2'd0, C_TYPE = 2'd1, C_ADDR = 2'd2;
  localparam logic [1:0] S_MGR = 2'd0, S_BW = 2'd1, S_CHH = 2'd2, S_CHL = 2'd3;
  localparam logic [31:0] CHH_INIT = 32'hFFFF_FFFE;

  logic [31:0]     mgr_q, chh_q, chl_q;
  logic [BW_W-1:0] bw_q;

  logic [1:0] sel;
  logic       aligned, in_grp, is_cas;
  assign sel     = req_addr[3:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign in_grp  = (req_addr >> 4) == '0;
  assign is_cas  = req_valid && !bus_reset && aligned && in_grp &&
                   req_kind == K_LOCK && req_ext == EXT_W'(CAS_CODE);

  logic [31:0] cur;
  always_comb begin
    case (sel)
      S_MGR:   cur = mgr_q;
      S_BW:    cur = 32'(bw_q);
      S_CHH:   cur = chh_q;
      default: cur = chl_q;
    endcase
  end

  // bandwidth delta rule
  logic [BW_W-1:0] bw_d, bw_a, take, give, bw_nxt;
  logic [BW_W:0]   bw_sum;
  logic            arg_big, alloc, bw_ok;
  assign bw_d    = req_data[BW_W-1:0];
  assign bw_a    = req_arg[BW_W-1:0];
  assign arg_big = |req_arg[31:BW_W];
  assign alloc   = bw_a >= bw_d;
  assign take    = bw_a - bw_d;
  assign give    = bw_d - bw_a;
  assign bw_sum  = {1'b0, bw_q} + {1'b0, give};
  assign bw_ok   = !arg_big && (alloc ? (bw_q >= take) : !bw_sum[BW_W]);
  assign bw_nxt  = alloc ? (bw_q - take) : bw_sum[BW_W-1:0];

  // channel bitmap rule, channel 31 kept allocated in high word bit 0
  logic [31:0] ch_data, ch_mask;
  logic        ch_ok;
  assign ch_data = (sel == S_CHH) ? (req_data & ~32'h1) : req_data;
  assign ch_mask = req_arg ^ ch_data;
  assign ch_ok   = (req_arg & ch_mask) == (cur & ch_mask);

  logic [1:0]  code_c;
  logic [31:0] val_c;
  always_comb begin
    code_c = C_OK;
    val_c  = '0;
    if (!aligned || req_kind == K_WRITE || req_kind == 2'd3) begin
      code_c = in_grp || !aligned ? C_TYPE : C_ADDR;
    end else if (!in_grp) begin
      code_c = C_ADDR;
    end else if (req_kind == K_READ) begin
      val_c = cur;
    end else if (req_ext != EXT_W'(CAS_CODE)) begin
      code_c = C_TYPE;
    end else begin
      case (sel)
        S_MGR:   val_c = cur;
        S_BW:    val_c = bw_ok ? req_arg : cur;
        default: val_c = ch_ok ? req_arg : cur;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      mgr_q     <= MGR_INIT;
      bw_q      <= BW_W'(BW_INIT);
      chh_q     <= CHH_INIT;
      chl_q     <= '1;
      rsp_valid <= 1'b0;
      rsp_code  <= C_OK;
      rsp_value <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= code_c;
      rsp_value <= val_c;
      if (is_cas) begin
        case (sel)
          S_MGR: if (mgr_q == req_arg) mgr_q <= req_data;
          S_BW:  if (bw_ok) bw_q <= bw_nxt;
          S_CHH: if (ch_ok) chh_q <= chh_q ^ ch_mask;
          default: if (ch_ok) chl_q <= chl_q ^ ch_mask;
        endcase
      end
    end
  end
endmodule

// File: rtl/iso_resmgr_regs_chk.sv
module iso_resmgr_regs_chk #(
  parameter int          ADDR_W   = 6,
  parameter int          EXT_W    = 4,
  parameter int          CAS_CODE = 2,
  parameter int          BW_W     = 13,
  parameter int          BW_INIT  = 4915,
  parameter logic [31:0] MGR_INIT = 32'h0000_003F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [EXT_W-1:0]  req_ext,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [31:0]       rsp_value,
  input logic [31:0]       mgr_q,
  input logic [BW_W-1:0]   bw_q,
  input logic [31:0]       chh_q,
  input logic [31:0]       chl_q
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == ($past(req_valid) && !$past(bus_reset) && $past(rst_n))); // R2

  AST_CH31_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !chh_q[0]); // R8

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_reset) |-> (mgr_q == MGR_INIT && bw_q == BW_W'(BW_INIT) &&
                          chh_q == 32'hFFFF_FFFE && chl_q == 32'hFFFF_FFFF)); // R1

  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind) == 2'd1) |-> (rsp_code != 2'd0)); // R9

  AST_MGR_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0 && $past(req_kind) == 2'd2 &&
     $past(req_addr) == '0) |-> (rsp_value == $past(mgr_q))); // R3

  AST_BW_ONLY_BY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_reset) &&
     !($past(req_valid) && $past(req_kind) == 2'd2 &&
       $past(req_addr) == ADDR_W'(4) && $past(req_ext) == EXT_W'(CAS_CODE)))
    |-> (bw_q == $past(bw_q))); // R10
endmodule

bind iso_resmgr_regs iso_resmgr_regs_chk #(
  .ADDR_W(ADDR_W), .EXT_W(EXT_W), .CAS_CODE(CAS_CODE),
  .BW_W(BW_W), .BW_INIT(BW_INIT), .MGR_INIT(MGR_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_kind(req_kind), .req_addr(req_addr), .req_ext(req_ext),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_value(rsp_value),
  .mgr_q(mgr_q), .bw_q(bw_q), .chh_q(chh_q), .chl_q(chl_q)
);

// File: tb/iso_resmgr_regs_tb.sv
module iso_resmgr_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, bus_reset, req_valid;
  logic [1:0]  req_kind;
  logic [5:0]  req_addr;
  logic [3:0]  req_ext;
  logic [31:0] req_data, req_arg;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_value;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_resmgr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_ext(req_ext),
    .req_data(req_data), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_value(rsp_value)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  kind;
    logic [5:0]  addr;
    logic [3:0]  ext;
    logic [31:0] data;
    logic [31:0] arg;
    logic [1:0]  ecode;
    logic [31:0] eval;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 2'd0, 6'h00, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_003F},         // R1
    '{4'd1, 2'd0, 6'h04, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_1333},         // R1
    '{4'd1, 2'd0, 6'h08, 4'd0, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFE},         // R1
    '{4'd1, 2'd0, 6'h0C, 4'd0, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFF},         // R1
    '{4'd3, 2'd2, 6'h00, 4'd2, 32'h5, 32'h3F, 2'd0, 32'h0000_003F},        // R3 swap
    '{4'd3, 2'd2, 6'h00, 4'd2, 32'h7, 32'h3F, 2'd0, 32'h0000_0005},        // R3 miss
    '{4'd2, 2'd0, 6'h00, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_0005},         // R2
    '{4'd5, 2'd2, 6'h04, 4'd2, 32'h1233, 32'h1333, 2'd0, 32'h0000_1333},   // R5 alloc
    '{4'd5, 2'd2, 6'h04, 4'd2, 32'h0, 32'h1300, 2'd0, 32'h0000_1233},      // R5 short
    '{4'd6, 2'd2, 6'h04, 4'd2, 32'h1333, 32'h1233, 2'd0, 32'h0000_1233},   // R6 free
    '{4'd6, 2'd2, 6'h04, 4'd2, 32'hD00, 32'h0, 2'd0, 32'h0000_1333},       // R6 overflow
    '{4'd6, 2'd2, 6'h04, 4'd2, 32'hCCC, 32'h0, 2'd0, 32'h0000_0000},       // R6 to 0x1FFF
    '{4'd6, 2'd0, 6'h04, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_1FFF},         // R6
    '{4'd5, 2'd2, 6'h04, 4'd2, 32'h0, 32'hCCC, 2'd0, 32'h0000_0CCC},       // R5
    '{4'd4, 2'd2, 6'h04, 4'd2, 32'h0, 32'h2000, 2'd0, 32'h0000_1333},      // R4 big arg
    '{4'd4, 2'd2, 6'h04, 4'd2, 32'hFFFF_2333, 32'h1333, 2'd0, 32'h0000_1333}, // R4 mask
    '{4'd4, 2'd0, 6'h04, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_0333},         // R4
    '{4'd6, 2'd2, 6'h04, 4'd2, 32'h1333, 32'h333, 2'd0, 32'h0000_0333},    // R6
    '{4'd7, 2'd2, 6'h0C, 4'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFF}, // R7
    '{4'd7, 2'd2, 6'h0C, 4'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFE}, // R7
    '{4'd7, 2'd2, 6'h0C, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'd0, 32'hFFFF_FFFE}, // R7
    '{4'd8, 2'd2, 6'h08, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'd0, 32'hFFFF_FFFE}, // R8
    '{4'd8, 2'd0, 6'h08, 4'd0, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFE},         // R8
    '{4'd7, 2'd2, 6'h08, 4'd2, 32'h7FFF_FFFE, 32'hFFFF_FFFE, 2'd0, 32'hFFFF_FFFE}, // R7
    '{4'd7, 2'd2, 6'h08, 4'd2, 32'h3FFF_FFFE, 32'hFFFF_FFFE, 2'd0, 32'h7FFF_FFFE}, // R7
    '{4'd8, 2'd2, 6'h08, 4'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 2'd0, 32'h7FFF_FFFE}, // R8
    '{4'd9, 2'd1, 6'h00, 4'd0, 32'hAA, 32'h0, 2'd1, 32'h0},                // R9
    '{4'd9, 2'd0, 6'h00, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_0005},         // R9
    '{4'd10, 2'd2, 6'h02, 4'd2, 32'h9, 32'h5, 2'd1, 32'h0},                // R10 unaligned
    '{4'd10, 2'd0, 6'h10, 4'd0, 32'h0, 32'h0, 2'd2, 32'h0},                // R10 out of group
    '{4'd10, 2'd2, 6'h00, 4'd1, 32'h9, 32'h5, 2'd1, 32'h0},                // R10 bad code
    '{4'd10, 2'd0, 6'h00, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0000_0005}         // R10
  };

  task automatic check(input int tag, input logic vld, input logic [1:0] code,
                       input logic [31:0] val, input logic evld,
                       input logic [1:0] ecode, input logic [31:0] eval);
    checks++;
    if (vld !== evld || (evld && (code !== ecode || val !== eval))) begin
      fails++;
      $display("FAIL R%0d: got vld=%0b code=%0d val=%h, expected vld=%0b code=%0d val=%h",
               tag, vld, code, val, evld, ecode, eval);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [5:0] a, input logic [3:0] e,
                       input logic [31:0] d, input logic [31:0] g);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_ext = e;
    req_data = d; req_arg = g;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_reset = 1'b0; req_valid = 1'b0; req_kind = '0;
    req_addr = '0; req_ext = '0; req_data = '0; req_arg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(2, rsp_valid, rsp_code, rsp_value, 1'b0, 2'd0, 32'h0);  // R2 idle: no response

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].kind, VEC[i].addr, VEC[i].ext, VEC[i].data, VEC[i].arg);
      check(int'(VEC[i].tag), rsp_valid, rsp_code, rsp_value, 1'b1, VEC[i].ecode, VEC[i].eval);
    end
    @(negedge clk);
    check(2, rsp_valid, rsp_code, rsp_value, 1'b0, 2'd0, 32'h0);  // R2 no stray response

    // R11: lock presented together with bus_reset is dropped
    bus_reset = 1'b1;
    issue(2'd2, 6'h00, 4'd2, 32'h9, 32'h5);
    bus_reset = 1'b0;
    check(11, rsp_valid, rsp_code, rsp_value, 1'b0, 2'd0, 32'h0);
    issue(2'd0, 6'h00, 4'd0, 32'h0, 32'h0);
    check(11, rsp_valid, rsp_code, rsp_value, 1'b1, 2'd0, 32'h0000_003F); // R11 and R1
    issue(2'd0, 6'h04, 4'd0, 32'h0, 32'h0);
    check(1, rsp_valid, rsp_code, rsp_value, 1'b1, 2'd0, 32'h0000_1333);  // R1
    issue(2'd0, 6'h08, 4'd0, 32'h0, 32'h0);
    check(1, rsp_valid, rsp_code, rsp_value, 1'b1, 2'd0, 32'hFFFF_FFFE);  // R1
    issue(2'd0, 6'h0C, 4'd0, 32'h0, 32'h0);
    check(1, rsp_valid, rsp_code, rsp_value, 1'b1, 2'd0, 32'hFFFF_FFFF);  // R1
    // R10: kind 3 refused
    issue(2'd3, 6'h04, 4'd2, 32'h0, 32'h0);
    check(10, rsp_valid, rsp_code, rsp_value, 1'b1, 2'd1, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R2: watchdog expired, got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule